// File: doc/BRIEF.md
# Virtual JTAG Node Discovery Sequencer

This block is a JTAG host controller that finds a debug node behind a virtual JTAG hub and selects it. It does not toggle TCK or TMS. It issues requests to an external scan engine instead. Each request is a test-logic-reset, an IR scan or a DR scan. A request carries a bit count and the bits to shift out. The engine answers with a done strobe and the last nibble it captured.

After a start pulse the sequencer does the following:

1. It resets the TAP.
2. It selects the hub with its info instruction.
3. It reads the hub configuration word as eight nibble scans. This word gives the node count and the virtual IR width m.
4. It reads one info word per node, eight nibble scans each, and compares each node's ID field with the target ID.
5. If a node matched, it writes the debug instruction into the matched node's virtual IR. It then leaves the physical IR on the virtual-DR opcode, so the debug logic can use the link straight away.

It reports the node address, m and the address width n. It raises a one-cycle done pulse, with an error flag when no node matched.

Top module: `vjNodeDiscovery`

## Requirements
- R1: After reset, busy, done, error and reqValid are all 0.
- R2: A start pulse while idle raises busy, and the first request is a test-logic-reset (reqKind 0).
- R3: Next come an IR scan (reqKind 1) of IR_LEN bits carrying 0x0E, zero-extended, and then a DR scan (reqKind 2) of 64 zero bits. Every IR request is IR_LEN bits long.
- R4: Next comes an IR scan carrying 0x0C, then eight 4-bit DR scans. Each returned nibble enters the top of a 32-bit word, so the first nibble ends up in bits 3:0. In the resulting hub word, bits 26:19 give the node count and bits 7:0 give m, and m is reported on mWidth.
- R5: For each node there are eight more 4-bit DR scans, so a run has 8*(count+1) nibble scans in all.
- R6: A node matches when bits 26:19 of its info word equal 0x08. nodeAddr is the 1-based position of the node. If several nodes match, the last one wins.
- R7: nWidth is the bit length of the node count (1 gives 1, 3 gives 2, 4 gives 3).
- R8: On a match the final three requests are:
  - IR 0x0E;
  - a DR scan of n+m bits carrying (nodeAddr << m) | 0x8;
  - IR 0x0C.
  Then done pulses with error 0.
- R9: With no match, including a node count of zero, done pulses with error 1 straight after the last node scan, and no further requests are issued.
- R10: A start while busy is ignored, and done is high for exactly one cycle.
- R11: Once raised, reqValid and the request fields stay stable until the cycle in which scanDone is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin discovery (taken only when idle) |
| scanDone | input | 1 | Engine finished the current request |
| scanIn | input | 4 | Last four bits captured by the engine's DR scan |
| reqValid | output | 1 | A request is pending |
| reqKind | output | 2 | 0 reset, 1 IR scan, 2 DR scan |
| reqLen | output | LEN_W | Number of bits to shift |
| reqData | output | DATA_W | Bits to shift out, LSB first |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | No matching node (valid with done, held until next start) |
| nodeAddr | output | 8 | Address of the matched node |
| mWidth | output | 8 | Virtual IR width read from the hub |
| nWidth | output | 4 | Address field width derived from node count |

## Verification
The hardest situation to reach from the ports is a hub whose node list has several matching IDs mixed with foreign ones, because the result depends on the scan engine returning exact nibbles in order across dozens of requests. The bench models the engine. It tracks the physical IR and, after each reset request, a nibble position. From a per-vector hub description it builds the hub and node words and returns them nibble by nibble. This lets table rows cover a single node, a target in last place, duplicate targets, no target and an empty hub. Each row also pulses start in the middle of a run and confirms the request log holds exactly one sequence.

// File: rtl/vjDiscPkg.sv
package vjDiscPkg;
  localparam int LEN_W = 9;

  typedef enum logic [1:0] {
    KIND_RESET = 2'd0,
    KIND_IR    = 2'd1,
    KIND_DR    = 2'd2
  } scanKind_e;

  typedef struct packed {
    logic clearAll;
    logic shiftNib;
    logic latchHub;
    logic checkNode;
    logic setError;
  } discStrobe_t;
endpackage

// File: rtl/vjDiscDatapath.sv
module vjDiscDatapath
  import vjDiscPkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int TARGET_ID = 8'h08,
  parameter int DEBUG_OP  = 4'h8
) (
  input  logic              clk,
  input  logic              rstN,
  input  discStrobe_t       strobe,
  input  logic [3:0]        scanIn,
  output logic              noNodes,
  output logic              lastNode,
  output logic              anyMatch,
  output logic [LEN_W-1:0]  cmdLen,
  output logic [DATA_W-1:0] cmdData,
  output logic              errFlag,
  output logic [7:0]        foundAddr,
  output logic [7:0]        mVal,
  output logic [3:0]        addrWidth
);
  logic [31:0] acc;
  logic [7:0]  nodeCnt;
  logic [7:0]  nodeIdx;
  logic        matched;
  logic        idHit;

  function automatic logic [3:0] bitLen(input logic [7:0] v);
    logic [3:0] r;
    logic [7:0] t;
    r = '0;
    t = v;
    for (int i = 0; i < 8; i++) begin
      if (t != 8'd0) begin
        r = r + 4'd1;
        t = t >> 1;
      end
    end
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clearAll) begin
      acc       <= '0;
      nodeCnt   <= '0;
      nodeIdx   <= '0;
      mVal      <= '0;
      foundAddr <= '0;
      matched   <= 1'b0;
      errFlag   <= 1'b0;
    end else begin
      if (strobe.shiftNib) acc <= {scanIn, acc[31:4]};
      if (strobe.latchHub) begin
        nodeCnt <= acc[26:19];
        mVal    <= acc[7:0];
        nodeIdx <= '0;
      end
      if (strobe.checkNode) begin
        if (idHit) begin
          foundAddr <= nodeIdx + 8'd1;
          matched   <= 1'b1;
        end
        nodeIdx <= nodeIdx + 8'd1;
      end
      if (strobe.setError) errFlag <= 1'b1;
    end
  end

  assign idHit     = (acc[26:19] == 8'(TARGET_ID));
  assign anyMatch  = matched | idHit;
  assign noNodes   = (nodeCnt == 8'd0);
  assign lastNode  = ({1'b0, nodeIdx} + 9'd1) == {1'b0, nodeCnt};
  assign addrWidth = bitLen(nodeCnt);
  assign cmdLen    = LEN_W'(addrWidth) + LEN_W'(mVal);
  assign cmdData   = (DATA_W'(foundAddr) << mVal) | DATA_W'(DEBUG_OP);
endmodule

// File: rtl/vjDiscControl.sv
module vjDiscControl
  import vjDiscPkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int IR_LEN  = 10,
  parameter int HUB_LEN = 64,
  parameter int VIR_OP  = 8'h0E,
  parameter int VDR_OP  = 8'h0C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              scanDone,
  input  logic              noNodes,
  input  logic              lastNode,
  input  logic              anyMatch,
  input  logic [LEN_W-1:0]  cmdLen,
  input  logic [DATA_W-1:0] cmdData,
  output discStrobe_t       strobe,
  output logic              reqValid,
  output scanKind_e         reqKind,
  output logic [LEN_W-1:0]  reqLen,
  output logic [DATA_W-1:0] reqData,
  output logic              busy,
  output logic              done
);
  typedef enum logic [3:0] {
    S_IDLE, S_TLR, S_VIR_A, S_HUBSEL, S_VDR_A, S_HUBNIB, S_HUBLATCH,
    S_NODESTART, S_NODENIB, S_NODECHK, S_VIR_B, S_CMD, S_VDR_B, S_DONE
  } state_e;

  state_e state, nextState;
  logic [2:0] nibCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      nibCnt <= '0;
    end else begin
      state <= nextState;
      if (state == S_VDR_A || state == S_NODESTART || state == S_NODECHK)
        nibCnt <= '0;
      else if (strobe.shiftNib)
        nibCnt <= nibCnt + 3'd1;
    end
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    reqValid  = 1'b0;
    reqKind   = KIND_RESET;
    reqLen    = '0;
    reqData   = '0;
    done      = 1'b0;
    unique case (state)
      S_IDLE: if (start) begin
        strobe.clearAll = 1'b1;
        nextState = S_TLR;
      end
      S_TLR: begin
        reqValid = 1'b1;
        if (scanDone) nextState = S_VIR_A;
      end
      S_VIR_A, S_VIR_B: begin
        reqValid = 1'b1;
        reqKind  = KIND_IR;
        reqLen   = LEN_W'(IR_LEN);
        reqData  = DATA_W'(VIR_OP);
        if (scanDone) nextState = (state == S_VIR_A) ? S_HUBSEL : S_CMD;
      end
      S_HUBSEL: begin
        reqValid = 1'b1;
        reqKind  = KIND_DR;
        reqLen   = LEN_W'(HUB_LEN);
        if (scanDone) nextState = S_VDR_A;
      end
      S_VDR_A, S_VDR_B: begin
        reqValid = 1'b1;
        reqKind  = KIND_IR;
        reqLen   = LEN_W'(IR_LEN);
        reqData  = DATA_W'(VDR_OP);
        if (scanDone) nextState = (state == S_VDR_A) ? S_HUBNIB : S_DONE;
      end
      S_HUBNIB, S_NODENIB: begin
        reqValid = 1'b1;
        reqKind  = KIND_DR;
        reqLen   = LEN_W'(4);
        if (scanDone) begin
          strobe.shiftNib = 1'b1;
          if (nibCnt == 3'd7)
            nextState = (state == S_HUBNIB) ? S_HUBLATCH : S_NODECHK;
        end
      end
      S_HUBLATCH: begin
        strobe.latchHub = 1'b1;
        nextState = S_NODESTART;
      end
      S_NODESTART: begin
        if (noNodes) begin
          strobe.setError = 1'b1;
          nextState = S_DONE;
        end else begin
          nextState = S_NODENIB;
        end
      end
      S_NODECHK: begin
        strobe.checkNode = 1'b1;
        if (!lastNode) nextState = S_NODENIB;
        else if (anyMatch) nextState = S_VIR_B;
        else begin
          strobe.setError = 1'b1;
          nextState = S_DONE;
        end
      end
      S_CMD: begin
        reqValid = 1'b1;
        reqKind  = KIND_DR;
        reqLen   = cmdLen;
        reqData  = cmdData;
        if (scanDone) nextState = S_VDR_B;
      end
      S_DONE: begin
        done = 1'b1;
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/vjNodeDiscovery.sv
module vjNodeDiscovery
  import vjDiscPkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IR_LEN = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              scanDone,
  input  logic [3:0]        scanIn,
  output logic              reqValid,
  output logic [1:0]        reqKind,
  output logic [LEN_W-1:0]  reqLen,
  output logic [DATA_W-1:0] reqData,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [7:0]        nodeAddr,
  output logic [7:0]        mWidth,
  output logic [3:0]        nWidth
);
  discStrobe_t       strobe;
  scanKind_e         kindInt;
  logic              noNodes, lastNode, anyMatch;
  logic [LEN_W-1:0]  cmdLen;
  logic [DATA_W-1:0] cmdData;

  vjDiscControl #(.DATA_W(DATA_W), .IR_LEN(IR_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .scanDone(scanDone),
    .noNodes(noNodes), .lastNode(lastNode), .anyMatch(anyMatch),
    .cmdLen(cmdLen), .cmdData(cmdData), .strobe(strobe),
    .reqValid(reqValid), .reqKind(kindInt), .reqLen(reqLen),
    .reqData(reqData), .busy(busy), .done(done)
  );

  vjDiscDatapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .scanIn(scanIn),
    .noNodes(noNodes), .lastNode(lastNode), .anyMatch(anyMatch),
    .cmdLen(cmdLen), .cmdData(cmdData), .errFlag(error),
    .foundAddr(nodeAddr), .mVal(mWidth), .addrWidth(nWidth)
  );

  assign reqKind = kindInt;
endmodule

// File: rtl/vjNodeDiscoveryChk.sv
module vjNodeDiscoveryChk #(
  parameter int DATA_W = 64,
  parameter int IR_LEN = 10,
  parameter int LEN_W  = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              scanDone,
  input logic              reqValid,
  input logic [1:0]        reqKind,
  input logic [LEN_W-1:0]  reqLen,
  input logic [DATA_W-1:0] reqData,
  input logic              busy,
  input logic              done
);
  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !scanDone |=> reqValid && $stable(reqKind) && $stable(reqLen) && $stable(reqData));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !reqValid && !done);

  // R3
  ir_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqKind == 2'd1 |-> reqLen == LEN_W'(IR_LEN));

  // R10
  done_ends_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);
endmodule

bind vjNodeDiscovery vjNodeDiscoveryChk #(.DATA_W(DATA_W), .IR_LEN(IR_LEN)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .scanDone(scanDone),
  .reqValid(reqValid), .reqKind(reqKind), .reqLen(reqLen),
  .reqData(reqData), .busy(busy), .done(done)
);

// File: tb/vjNodeDiscovery_bench.sv
`timescale 1ns/1ps
module vjNodeDiscovery_bench;
  localparam int DATA_W = 64;
  localparam int IR_LEN = 10;
  localparam int LEN_W  = 9;

  typedef struct packed {
    logic [7:0]  nodes;
    logic [7:0]  m;
    logic [31:0] ids;
    logic [7:0]  addr;
    logic        err;
  } vec_t;

  localparam int NVEC = 5;
  localparam vec_t VECS [NVEC] = '{
    '{8'd1, 8'd4,  32'h00000008, 8'd1, 1'b0},
    '{8'd3, 8'd4,  32'h00088400, 8'd3, 1'b0},
    '{8'd4, 8'd5,  32'h00080408, 8'd3, 1'b0},
    '{8'd2, 8'd4,  32'h00008400, 8'd0, 1'b1},
    '{8'd4, 8'd12, 32'h04000884, 8'd2, 1'b0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic scanDone = 1'b0;
  logic [3:0] scanIn = 4'd0;
  logic reqValid, busy, done, error;
  logic [1:0] reqKind;
  logic [LEN_W-1:0] reqLen;
  logic [DATA_W-1:0] reqData;
  logic [7:0] nodeAddr, mWidth;
  logic [3:0] nWidth;

  always #2 clk = ~clk;

  vjNodeDiscovery #(.DATA_W(DATA_W), .IR_LEN(IR_LEN)) u_vjNodeDiscovery (
    .clk(clk), .rstN(rstN), .start(start), .scanDone(scanDone), .scanIn(scanIn),
    .reqValid(reqValid), .reqKind(reqKind), .reqLen(reqLen), .reqData(reqData),
    .busy(busy), .done(done), .error(error), .nodeAddr(nodeAddr),
    .mWidth(mWidth), .nWidth(nWidth)
  );

  int checks = 0;
  int fails = 0;

  logic [1:0]        logKind [64];
  logic [LEN_W-1:0]  logLen  [64];
  logic [DATA_W-1:0] logData [64];
  int logCnt = 0;
  int stableErr = 0;

  logic [7:0]  curN;
  logic [7:0]  curM;
  logic [31:0] curIds;

  function automatic logic [31:0] wordAt(int idx);
    if (idx == 0) return {5'd1, curN, 11'h06E, curM};
    return {5'd1, curIds[8*(idx-1) +: 8], 11'h06E, 8'(idx)};
  endfunction

  function automatic logic [3:0] bitLenRef(int v);
    int w = 0;
    while (v != 0) begin v = v >> 1; w++; end
    return 4'(w);
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // scan engine model
  initial begin
    logic [7:0] curIr;
    int pos;
    logic [1:0] k;
    logic [LEN_W-1:0] l;
    logic [DATA_W-1:0] d;
    logic [3:0] nib;
    curIr = 8'h00;
    pos = 0;
    forever begin
      @(negedge clk);
      if (rstN && reqValid) begin
        k = reqKind; l = reqLen; d = reqData; nib = 4'd0;
        if (logCnt < 64) begin
          logKind[logCnt] = k; logLen[logCnt] = l; logData[logCnt] = d;
        end
        logCnt++;
        if (k == 2'd0) pos = 0;
        else if (k == 2'd1) curIr = d[7:0];
        else if (curIr == 8'h0C && l == LEN_W'(4)) begin
          nib = wordAt(pos / 8)[4*(pos % 8) +: 4];
          pos++;
        end
        for (int c = 0; c < 2; c++) begin
          @(negedge clk);
          if (!reqValid || reqKind !== k || reqLen !== l || reqData !== d) stableErr++;
        end
        scanIn = nib;
        scanDone = 1'b1;
        @(negedge clk);
        scanDone = 1'b0;
      end
    end
  end

  task automatic runOnce(output logic sawDone);
    logCnt = 0;
    stableErr = 0;
    sawDone = 1'b0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy after start", 64'(busy), 64'd1);
    repeat (20) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < 5000; t++) begin
      if (done) begin sawDone = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic checkRun(logic [7:0] n, logic [7:0] m, logic [7:0] addr, logic err);
    int nibs;
    int base;
    logic [3:0] nw;
    logic sawDone;
    curN = n; curM = m;
    runOnce(sawDone);
    check("R10 done reached", 64'(sawDone), 64'd1);
    check("R9 error flag", 64'(error), 64'(err));
    check("R4 m reported", 64'(mWidth), 64'(m));
    @(negedge clk);
    check("R10 done one cycle", 64'(done), 64'd0);
    check("R2 first request reset", 64'(logKind[0]), 64'd0);
    check("R3 VIR select", {logKind[1], 7'(logLen[1]), logData[1][15:0]}, {2'd1, 7'd10, 16'h000E});
    check("R3 hub select zeros", {logKind[2], 7'(logLen[2]), logData[2][15:0]}, {2'd2, 7'd64, 16'h0000});
    check("R4 VDR select", {logKind[3], 7'(logLen[3]), logData[3][15:0]}, {2'd1, 7'd10, 16'h000C});
    nibs = 0;
    for (int i = 4; i < logCnt && i < 64; i++)
      if (logKind[i] == 2'd2 && logLen[i] == LEN_W'(4)) nibs++;
    check("R5 nibble scan count", 64'(nibs), 64'(8 * (int'(n) + 1)));
    check("R11 request stable", 64'(stableErr), 64'd0);
    base = 4 + 8 * (int'(n) + 1);
    if (err) begin
      check("R9 no command scans", 64'(logCnt), 64'(base));
    end else begin
      nw = bitLenRef(int'(n));
      check("R6 node address", 64'(nodeAddr), 64'(addr));
      check("R7 address width", 64'(nWidth), 64'(nw));
      check("R10 single sequence", 64'(logCnt), 64'(base + 3));
      check("R8 second VIR", {logKind[base], logData[base][15:0]}, {2'd1, 16'h000E});
      check("R8 command length", {logKind[base+1], 7'(logLen[base+1])}, {2'd2, 7'(int'(nw) + int'(m))});
      check("R8 command data", logData[base+1], (64'(addr) << m) | 64'h8);
      check("R8 final VDR", {logKind[base+2], logData[base+2][15:0]}, {2'd1, 16'h000C});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    curN = 8'd0; curM = 8'd0; curIds = 32'd0;
    repeat (3) @(negedge clk);
    check("R1 busy at reset", 64'(busy), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle outputs", {60'd0, busy, done, error, reqValid}, 64'd0);

    for (int v = 0; v < NVEC; v++) begin
      curIds = VECS[v].ids;
      checkRun(VECS[v].nodes, VECS[v].m, VECS[v].addr, VECS[v].err);
    end

    // empty hub: no nodes at all
    curIds = 32'd0;
    checkRun(8'd0, 8'd6, 8'd0, 1'b1);

    // result holds while idle, then reset clears it
    repeat (5) @(negedge clk);
    check("R9 error held while idle", 64'(error), 64'd1);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset clears error", {62'd0, error, busy}, 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule